// File: doc/BRIEF.md
# Quad-Accumulator Integer Multiply-Accumulate Unit

This block is a coprocessor-side arithmetic unit that multiplies two 32-bit integers and folds the product into one of four 72-bit accumulators. It can also add, subtract, clear, preload and shift those accumulators. The 72-bit width leaves eight guard bits above a 64-bit product, so long sums do not lose their upper bits before they are read. Commands arrive on a valid/ready stream. Each command carries an opcode, an accumulator index, a signedness bit and two operands. Read results leave on a second valid/ready stream. Each result carries the full 72-bit value and a 64-bit view. The view is either saturated or truncated, as chosen by a plain mode pin.

Write commands pass through three stages: operand capture, a registered product, then the accumulate. The accumulate stage reads back the value it wrote in the previous cycle, so a chain of dependent accumulations can issue one per cycle. A read is served from the accumulator at issue time. An interlock therefore holds a read off while a write to the same accumulator is still in flight, and it also holds the read off while the previous result has not been taken.

Back-pressure rules:
- A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high.
- A result transfers on a clock edge where `res_valid` and `res_ready` are both high.
- Commands other than reads are never refused.

Top module: `mac_unit`

## Requirements
- R1: Opcode 0 adds a*b to the selected accumulator. When `cmd_signed` is 1 the operands are sign-extended; when it is 0 they are zero-extended.
- R2: Opcode 1 subtracts a*b from the selected accumulator, with the same extension rule as R1.
- R3: Opcode 2 sets the accumulator to zero. Opcode 3 loads the 64-bit value {cmd_b, cmd_a} (cmd_b is the upper half), sign-extended to 72 bits.
- R4: Opcode 4 shifts the selected accumulator arithmetically right by cmd_a[5:0].
- R5: The four accumulators are independent. A command changes only the accumulator selected by `cmd_acc`.
- R6: Accumulators keep all 72 bits, and `res_full` returns sums that exceed the 64-bit range exactly.
- R7: Opcode 5 reads the selected accumulator. `res_view` equals the low 64 bits when bits 71..63 are all equal. Otherwise, with `sat_mode`=1 it is the most positive or most negative signed 64-bit value, following bit 71, and with `sat_mode`=0 it is the low 64 bits. `sat_mode` is sampled when the read transfers. `res_valid` rises only in the cycle after a read transfers.
- R8: A read stalls for exactly two cycles when it immediately follows a write to the same accumulator. A read of a different accumulator is not stalled. Non-read commands always see `cmd_ready` high.
- R9: Dependent accumulations to one accumulator can issue on consecutive cycles and still give the exact running sum.
- R10: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_full` and `res_view` hold their values, and a new read sees `cmd_ready` low.
- R11: Opcodes 6 and 7 are accepted and change no accumulator.
- R12: After reset all accumulators read zero and `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Opcode (0 mac, 1 msub, 2 clear, 3 load, 4 shift, 5 read) |
| cmd_acc | input | 2 | Accumulator index |
| cmd_signed | input | 1 | 1 sign-extends the operands, 0 zero-extends them |
| cmd_a | input | 32 | Operand A, low load half, shift amount in bits 5..0 |
| cmd_b | input | 32 | Operand B, high load half |
| sat_mode | input | 1 | 1 saturates the 64-bit view, 0 truncates it |
| res_valid | output | 1 | Read result present |
| res_ready | input | 1 | Result taken by the consumer |
| res_full | output | 72 | Full accumulator value |
| res_view | output | 64 | Saturated or truncated 64-bit value |

## Verification
The following are protocol and ordering rules, checked on every cycle by the assertions:
- non-read commands are never refused;
- a read cannot transfer in the cycle right after a write to the same accumulator;
- results hold steady under back-pressure;
- a result appears only after a read;
- the 64-bit view is exact whenever the value fits.

The following depend on data values and timing across several commands, so only the bench scenarios can show them:
- the arithmetic of each opcode, under both signedness settings;
- the guard-bit sums and the saturation corners;
- the exact two-cycle stall count;
- that unused opcodes leave state untouched.

// File: rtl/mac_pkg.sv
package mac_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef logic [2:0] op_t;

  localparam op_t OP_MAC  = 3'd0;
  localparam op_t OP_MSU  = 3'd1;
  localparam op_t OP_CLR  = 3'd2;
  localparam op_t OP_LOAD = 3'd3;
  localparam op_t OP_SHR  = 3'd4;
  localparam op_t OP_READ = 3'd5;

  function automatic logic op_writes(op_t op);
    return op <= OP_SHR;
  endfunction
endpackage

// File: rtl/mac_mul_pipe.sv
module mac_mul_pipe
  import mac_pkg::*;
#(
  parameter int W    = 32,
  parameter int SELW = 2,
  localparam int PW  = 2 * W + 2,
  localparam int LW  = 2 * W,
  localparam int SHW = $clog2(LW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_v,
  input  op_t             in_op,
  input  logic [SELW-1:0] in_sel,
  input  logic            in_sgn,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_b,
  output logic            s1_v,
  output logic [SELW-1:0] s1_sel,
  output logic            wb_v,
  output op_t             wb_op,
  output logic [SELW-1:0] wb_sel,
  output logic [PW-1:0]   wb_prod,
  output logic [LW-1:0]   wb_ld,
  output logic [SHW-1:0]  wb_sh
);
  op_t                s1_op;
  logic signed [W:0]  s1_a;
  logic signed [W:0]  s1_b;
  logic [LW-1:0]      s1_ld;
  logic [SHW-1:0]     s1_sh;
  logic signed [PW-1:0] prod;

  // stage 1: operand capture with signedness extension
  always_ff @(posedge clk) begin
    if (!rst_n) s1_v <= 1'b0;
    else        s1_v <= in_v;
    s1_op  <= in_op;
    s1_sel <= in_sel;
    s1_a   <= {in_sgn & in_a[W-1], in_a};
    s1_b   <= {in_sgn & in_b[W-1], in_b};
    s1_ld  <= {in_b, in_a};
    s1_sh  <= in_a[SHW-1:0];
  end

  assign prod = s1_a * s1_b;

  // stage 2: registered product
  always_ff @(posedge clk) begin
    if (!rst_n) wb_v <= 1'b0;
    else        wb_v <= s1_v;
    wb_op   <= s1_op;
    wb_sel  <= s1_sel;
    wb_prod <= prod;
    wb_ld   <= s1_ld;
    wb_sh   <= s1_sh;
  end
endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank
  import mac_pkg::*;
#(
  parameter int AW   = 72,
  parameter int NACC = 4,
  parameter int PW   = 66,
  parameter int LW   = 64,
  parameter int SHW  = 6,
  localparam int SELW = $clog2(NACC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wb_v,
  input  op_t             wb_op,
  input  logic [SELW-1:0] wb_sel,
  input  logic [PW-1:0]   wb_prod,
  input  logic [LW-1:0]   wb_ld,
  input  logic [SHW-1:0]  wb_sh,
  input  logic [SELW-1:0] rd_sel,
  output logic [AW-1:0]   rd_data
);
  logic [AW-1:0] acc_q [NACC];
  logic [AW-1:0] cur;
  logic [AW-1:0] prod_x;
  logic [AW-1:0] nxt;
  logic          wr_en;

  assign cur    = acc_q[wb_sel];
  assign prod_x = {{(AW-PW){wb_prod[PW-1]}}, wb_prod};
  assign wr_en  = wb_v && op_writes(wb_op);

  always_comb begin
    case (wb_op)
      OP_MAC:  nxt = cur + prod_x;
      OP_MSU:  nxt = cur - prod_x;
      OP_CLR:  nxt = '0;
      OP_LOAD: nxt = {{(AW-LW){wb_ld[LW-1]}}, wb_ld};
      OP_SHR:  nxt = $signed(cur) >>> wb_sh;
      default: nxt = cur;
    endcase
  end

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    always_ff @(posedge clk) begin
      if (!rst_n)                                acc_q[g] <= '0;
      else if (wr_en && wb_sel == SELW'(g))      acc_q[g] <= nxt;
    end
  end

  assign rd_data = acc_q[rd_sel];
endmodule

// File: rtl/mac_readout.sv
module mac_readout #(
  parameter int AW = 72,
  parameter int VW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic [AW-1:0] rd_data,
  input  logic          sat_mode,
  input  logic          res_ready,
  output logic          res_valid,
  output logic [AW-1:0] res_full,
  output logic [VW-1:0] res_view
);
  logic          fits;
  logic [VW-1:0] clip;
  logic [VW-1:0] view;

  assign fits = (&rd_data[AW-1:VW-1]) | ~(|rd_data[AW-1:VW-1]);
  assign clip = rd_data[AW-1] ? {1'b1, {(VW-1){1'b0}}} : {1'b0, {(VW-1){1'b1}}};
  assign view = (sat_mode && !fits) ? clip : rd_data[VW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_full  <= '0;
      res_view  <= '0;
    end else if (rd_fire) begin
      res_valid <= 1'b1;
      res_full  <= rd_data;
      res_view  <= view;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OPW  = 32,
  parameter int AW   = 72,
  parameter int NACC = 4,
  localparam int SELW = $clog2(NACC),
  localparam int PW   = 2 * OPW + 2,
  localparam int LW   = 2 * OPW,
  localparam int VW   = 2 * OPW,
  localparam int SHW  = $clog2(LW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [SELW-1:0] cmd_acc,
  input  logic            cmd_signed,
  input  logic [OPW-1:0]  cmd_a,
  input  logic [OPW-1:0]  cmd_b,
  input  logic            sat_mode,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [AW-1:0]   res_full,
  output logic [VW-1:0]   res_view
);
  logic            s1_v, wb_v;
  logic [SELW-1:0] s1_sel, wb_sel;
  op_t             wb_op;
  logic [PW-1:0]   wb_prod;
  logic [LW-1:0]   wb_ld;
  logic [SHW-1:0]  wb_sh;
  logic [AW-1:0]   rd_data;
  logic            is_read, pending, out_free, fire;

  // interlock: reads sample the accumulator directly, so wait for in-flight writes
  assign is_read   = (cmd_op == OP_READ);
  assign pending   = (s1_v && s1_sel == cmd_acc) || (wb_v && wb_sel == cmd_acc);
  assign out_free  = !res_valid || res_ready;
  assign cmd_ready = !is_read || (!pending && out_free);
  assign fire      = cmd_valid && cmd_ready;

  mac_mul_pipe #(.W(OPW), .SELW(SELW)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_v(fire && !is_read), .in_op(cmd_op), .in_sel(cmd_acc),
    .in_sgn(cmd_signed), .in_a(cmd_a), .in_b(cmd_b),
    .s1_v(s1_v), .s1_sel(s1_sel),
    .wb_v(wb_v), .wb_op(wb_op), .wb_sel(wb_sel),
    .wb_prod(wb_prod), .wb_ld(wb_ld), .wb_sh(wb_sh)
  );

  mac_acc_bank #(.AW(AW), .NACC(NACC), .PW(PW), .LW(LW), .SHW(SHW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wb_v(wb_v), .wb_op(wb_op), .wb_sel(wb_sel),
    .wb_prod(wb_prod), .wb_ld(wb_ld), .wb_sh(wb_sh),
    .rd_sel(cmd_acc), .rd_data(rd_data)
  );

  mac_readout #(.AW(AW), .VW(VW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .rd_fire(fire && is_read), .rd_data(rd_data), .sat_mode(sat_mode),
    .res_ready(res_ready), .res_valid(res_valid),
    .res_full(res_full), .res_view(res_view)
  );
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk
  import mac_pkg::*;
#(
  parameter int OPW  = 32,
  parameter int AW   = 72,
  parameter int NACC = 4,
  localparam int SELW = $clog2(NACC),
  localparam int VW   = 2 * OPW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [2:0]      cmd_op,
  input logic [SELW-1:0] cmd_acc,
  input logic            res_valid,
  input logic            res_ready,
  input logic [AW-1:0]   res_full,
  input logic [VW-1:0]   res_view
);
  a_r8_writes_never_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != OP_READ) |-> cmd_ready);

  a_r8_no_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op != OP_READ) |=>
      !(cmd_valid && cmd_ready && cmd_op == OP_READ && cmd_acc == $past(cmd_acc)));

  a_r10_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_full) && $stable(res_view)));

  a_r10_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_READ && res_valid && !res_ready) |-> !cmd_ready);

  a_r7_result_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(cmd_valid && cmd_ready && cmd_op == OP_READ));

  a_r7_view_exact_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ((&res_full[AW-1:VW-1]) || !(|res_full[AW-1:VW-1])))
      |-> res_view == res_full[VW-1:0]);
endmodule

bind mac_unit mac_unit_chk #(.OPW(OPW), .AW(AW), .NACC(NACC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_acc(cmd_acc), .res_valid(res_valid),
  .res_ready(res_ready), .res_full(res_full), .res_view(res_view)
);

// File: tb/mac_unit_bench.sv
module mac_unit_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [1:0]  cmd_acc = 2'd0;
  logic        cmd_signed = 1'b0;
  logic [31:0] cmd_a = '0;
  logic [31:0] cmd_b = '0;
  logic        sat_mode = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [71:0] res_full;
  logic [63:0] res_view;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [71:0] full;
    logic [63:0] view;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic signed [71:0] model [4];

  always #2 clk = ~clk;

  mac_unit u_mac_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_acc(cmd_acc), .cmd_signed(cmd_signed),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .sat_mode(sat_mode),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_full(res_full), .res_view(res_view)
  );

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic signed [71:0] mprod(input bit sgn, input logic [31:0] a, input logic [31:0] b);
    logic signed [32:0] ea, eb;
    logic signed [71:0] r;
    ea = sgn ? $signed({a[31], a}) : $signed({1'b0, a});
    eb = sgn ? $signed({b[31], b}) : $signed({1'b0, b});
    r = ea * eb;
    return r;
  endfunction

  function automatic logic [63:0] vexp(input logic [71:0] f, input bit sat);
    bit fit;
    fit = (&f[71:63]) || !(|f[71:63]);
    if (fit || !sat) return f[63:0];
    return f[71] ? 64'h8000_0000_0000_0000 : 64'h7FFF_FFFF_FFFF_FFFF;
  endfunction

  // driver: present at negedge, wait for ready, update model / push expectation on transfer
  task automatic issue(input logic [2:0] op, input logic [1:0] sel, input bit sgn,
                       input logic [31:0] a, input logic [31:0] b, input string tag,
                       output int stalls);
    exp_t e;
    stalls = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_acc = sel; cmd_signed = sgn; cmd_a = a; cmd_b = b;
    #0.5;
    while (!cmd_ready) begin
      stalls++;
      @(negedge clk);
      #0.5;
    end
    case (op)
      3'd0: model[sel] = model[sel] + mprod(sgn, a, b);
      3'd1: model[sel] = model[sel] - mprod(sgn, a, b);
      3'd2: model[sel] = '0;
      3'd3: model[sel] = {{8{b[31]}}, b, a};
      3'd4: model[sel] = model[sel] >>> a[5:0];
      3'd5: begin
        e.full = model[sel];
        e.view = vexp(model[sel], sat_mode);
        e.tag  = tag;
        q.push_back(e);
      end
      default: ;
    endcase
    @(posedge clk);
    #0.2;
    cmd_valid = 1'b0;
  endtask

  task automatic go(input logic [2:0] op, input logic [1:0] sel, input bit sgn,
                    input logic [31:0] a, input logic [31:0] b, input string tag);
    int s;
    issue(op, sel, sgn, a, b, tag, s);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: compare each result that transfers on the next edge
  always @(negedge clk) begin
    #0.8;
    if (rst_n && res_valid && res_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7 unexpected result", res_full, 72'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(res_full == e.full, {e.tag, " full"}, res_full, e.full);
        chk(res_view == e.view, {e.tag, " view"}, {8'd0, res_view}, {8'd0, e.view});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int st;
    logic [71:0] held;
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cmd_op = 3'd5;
    #0.5;
    chk(res_valid == 1'b0, "R12 res_valid after reset", {71'd0, res_valid}, 72'd0);
    chk(cmd_ready == 1'b1, "R12 ready after reset", {71'd0, cmd_ready}, 72'd1);
    for (int i = 0; i < 4; i++) go(3'd5, 2'(i), 0, 0, 0, "R12 zero after reset");

    // R1 signed and unsigned multiply-accumulate
    go(3'd0, 2'd0, 1, 32'hFFFF_FFFD, 32'd7, "");
    go(3'd0, 2'd0, 1, 32'd100000, 32'hFFFE_7960, "");
    go(3'd5, 2'd0, 0, 0, 0, "R1 signed mac");
    go(3'd0, 2'd1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "");
    go(3'd5, 2'd1, 0, 0, 0, "R1 unsigned mac");
    go(3'd0, 2'd1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "");
    go(3'd5, 2'd1, 0, 0, 0, "R1 signed minus one squared");

    // R9 back-to-back dependent accumulations, then R8 stall count on same acc
    for (int i = 0; i < 6; i++) go(3'd0, 2'd2, 1, 32'(i * 7919 - 20000), 32'(31 - i * 1000), "");
    issue(3'd5, 2'd2, 0, 0, 0, "R9 chained sum", st);
    chk(st == 2, "R8 stall after write same acc", 72'(st), 72'd2);

    // R2 multiply-subtract
    go(3'd1, 2'd2, 1, 32'd1234567, 32'hFFFF_FFA7, "");
    go(3'd5, 2'd2, 0, 0, 0, "R2 msub");

    // R3 clear and load
    go(3'd2, 2'd2, 0, 32'hDEAD_BEEF, 32'h1234_5678, "");
    go(3'd5, 2'd2, 0, 0, 0, "R3 clear");
    go(3'd3, 2'd2, 0, 32'h89AB_CDEF, 32'hF012_3456, "");
    go(3'd5, 2'd2, 0, 0, 0, "R3 load sign-extended");

    // R4 arithmetic right shift
    go(3'd4, 2'd2, 0, 32'd8, 0, "");
    go(3'd5, 2'd2, 0, 0, 0, "R4 shift by 8");
    go(3'd4, 2'd2, 0, 32'hFFFF_FFC0 | 32'd63, 0, "");
    go(3'd5, 2'd2, 0, 0, 0, "R4 shift by 63");

    // R6 guard bits, R7 saturation both directions
    go(3'd3, 2'd3, 0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "");
    for (int i = 0; i < 100; i++) go(3'd0, 2'd3, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "");
    sat_mode = 1'b0;
    go(3'd5, 2'd3, 0, 0, 0, "R6 guard sum truncated view");
    sat_mode = 1'b1;
    go(3'd5, 2'd3, 0, 0, 0, "R7 positive saturate");
    go(3'd3, 2'd3, 0, 32'd0, 32'h8000_0000, "");
    go(3'd1, 2'd3, 0, 32'd1, 32'd1, "");
    go(3'd5, 2'd3, 0, 0, 0, "R7 negative saturate");
    sat_mode = 1'b0;
    go(3'd5, 2'd3, 0, 0, 0, "R7 negative truncate");

    // R8 read of another accumulator is not stalled
    go(3'd0, 2'd0, 1, 32'd5, 32'd5, "");
    issue(3'd5, 2'd1, 0, 0, 0, "R5 other acc untouched", st);
    chk(st == 0, "R8 no stall other acc", 72'(st), 72'd0);
    go(3'd5, 2'd0, 0, 0, 0, "R5 acc0 own value");

    // R11 unused opcodes
    go(3'd6, 2'd1, 1, 32'h1111_1111, 32'h2222_2222, "");
    go(3'd7, 2'd1, 1, 32'h3333_3333, 32'h4444_4444, "");
    go(3'd5, 2'd1, 0, 0, 0, "R11 unused opcodes no effect");

    // R10 back-pressure on the result stream
    drain();
    res_ready = 1'b0;
    go(3'd5, 2'd0, 0, 0, 0, "R10 held result");
    @(negedge clk);
    held = res_full;
    cmd_valid = 1'b1; cmd_op = 3'd5; cmd_acc = 2'd1;
    for (int i = 0; i < 3; i++) begin
      #0.5;
      chk(cmd_ready == 1'b0, "R10 read blocked", {71'd0, cmd_ready}, 72'd0);
      chk(res_valid == 1'b1 && res_full == held, "R10 result held", res_full, held);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    res_ready = 1'b1;
    go(3'd5, 2'd1, 0, 0, 0, "R10 read after release");

    drain();
    chk(q.size() == 0, "R7 all results returned", 72'(q.size()), 72'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule